// File: doc/BRIEF.md
# Weighted Page Eviction Selector

This block picks which frame of a local cache of shared pages should be emptied when space is needed. Each resident frame carries a sharing kind and a recency age. The kind is a plain read-only copy, an owned read-only copy or a writable copy. A fill or an access touches a frame, which keeps the ages current. When the caller raises a request, the block scores every frame and names the best candidate one cycle later. The score adds a programmable per-kind weight to a programmable multiple of the frame's age.

The response also says how the page leaves. A plain read-only copy can simply be discarded, because another node still holds the data. An owned or writable page has to be shipped to a node that has free memory. That node is taken from a one-hot-per-node hint input. If shipping is needed and no node has room, the response raises a stall flag. Moving the data is the caller's job.

Top module: `victim_sel`

## Requirements
- R1: After reset every frame is empty and `respValid` is low; a request then names frame 0 with the drop outcome.
- R2: `respValid` is high for exactly the cycle after each cycle in which `reqValid` was high, and low otherwise. The response reflects the table as it stood in the request cycle.
- R3: While any frame is empty, the victim is the lowest-numbered empty frame, with `respXfer` = 0 and `respStall` = 0.
- R4: When all frames are occupied, each frame scores kindWeight + `wtAge` × age, and the highest score wins. kindWeight is `wtReadOnly` for kind code 0, `wtOwned` for code 1, and `wtWritable` for code 2 (code 3 also uses `wtWritable`).
- R5: Equal top scores are resolved toward the lowest frame index.
- R6: A touch sets the touched frame's age to 0 and adds one to the age of every other occupied frame. Ages stop at 2^AGE_W−1. An access to an empty frame changes nothing.
- R7: A fill marks the frame occupied with the kind given on `fillKind` and counts as a touch. When a fill and an access arrive in the same cycle, the fill is the touch.
- R8: `respXfer` is 0 for an occupied victim of kind 0 and 1 for kinds 1, 2 and 3.
- R9: `respNode` is the index of the lowest set bit of `freeNodeMask`, or 0 when no bit is set. `respStall` = `respXfer` AND (`freeNodeMask` = 0), sampled in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fillValid | input | 1 | Load a frame with a new page |
| fillIdx | input | IDX_W | Frame being filled |
| fillKind | input | 2 | Kind of the new page: 0 read-only, 1 owned read-only, 2 writable |
| accValid | input | 1 | A frame was referenced |
| accIdx | input | IDX_W | Frame referenced |
| wtReadOnly | input | WEIGHT_W | Score weight of kind 0 |
| wtOwned | input | WEIGHT_W | Score weight of kind 1 |
| wtWritable | input | WEIGHT_W | Score weight of kind 2 |
| wtAge | input | WEIGHT_W | Multiplier applied to age |
| freeNodeMask | input | NODE_CNT | Bit n set means node n has free memory |
| reqValid | input | 1 | Ask for a victim |
| respValid | output | 1 | Response fields are valid |
| respIdx | output | IDX_W | Chosen frame |
| respXfer | output | 1 | 1 = page must be shipped, 0 = drop |
| respNode | output | NODE_W | Destination node for shipping |
| respStall | output | 1 | Shipping needed but no node has room |

## Verification
Some properties are checked on every cycle:
- the response timing;
- that an age never grows by more than one per cycle;
- that an empty frame is never passed over for an occupied one;
- that no occupied frame outscores the chosen one, or ties with it at a lower index;
- that a stall only appears with a ship outcome.

Other behaviours are shown only by the bench's scenarios. These are the exact victim under particular weight settings, age saturation changing the outcome, destination selection from the hint, and the return to an empty table after reset.

// File: rtl/victim_sel_pkg.sv
package victim_sel_pkg;

  typedef enum logic [1:0] {
    KIND_RO    = 2'd0,
    KIND_OWNED = 2'd1,
    KIND_WRITE = 2'd2,
    KIND_SPARE = 2'd3
  } pageKind_e;

  typedef struct packed {
    logic touch;
    logic fill;
    logic capture;
  } ctrlStrobe_t;

endpackage

// File: rtl/victim_sel_ctrl.sv
module victim_sel_ctrl
  import victim_sel_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fillValid,
  input  logic [IDX_W-1:0] fillIdx,
  input  logic             accValid,
  input  logic [IDX_W-1:0] accIdx,
  input  logic             reqValid,
  output ctrlStrobe_t      strobe,
  output logic [IDX_W-1:0] touchIdx,
  output logic             respValid
);

  always_comb begin
    strobe.touch   = fillValid | accValid;
    strobe.fill    = fillValid;
    strobe.capture = reqValid;
    touchIdx       = fillValid ? fillIdx : accIdx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) respValid <= 1'b0;
    else        respValid <= reqValid;
  end

  AST_RESP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> respValid);  // R2
  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> !respValid);  // R2

endmodule

// File: rtl/victim_sel_dp.sv
module victim_sel_dp
  import victim_sel_pkg::*;
#(
  parameter int NUM_FRAMES = 8,
  parameter int AGE_W      = 4,
  parameter int WEIGHT_W   = 8,
  parameter int NODE_CNT   = 4,
  localparam int IDX_W     = $clog2(NUM_FRAMES),
  localparam int NODE_W    = (NODE_CNT > 1) ? $clog2(NODE_CNT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ctrlStrobe_t         strobe,
  input  logic [IDX_W-1:0]    touchIdx,
  input  logic [1:0]          fillKind,
  input  logic [WEIGHT_W-1:0] wtReadOnly,
  input  logic [WEIGHT_W-1:0] wtOwned,
  input  logic [WEIGHT_W-1:0] wtWritable,
  input  logic [WEIGHT_W-1:0] wtAge,
  input  logic [NODE_CNT-1:0] freeNodeMask,
  output logic [IDX_W-1:0]    respIdx,
  output logic                respXfer,
  output logic [NODE_W-1:0]   respNode,
  output logic                respStall
);

  localparam int SCORE_W = WEIGHT_W + AGE_W + 1;
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic [NUM_FRAMES-1:0] validQ;
  pageKind_e             kindQ [NUM_FRAMES];
  logic [AGE_W-1:0]      ageQ  [NUM_FRAMES];
  logic [SCORE_W-1:0]    score [NUM_FRAMES];
  logic                  touchOk;

  assign touchOk = strobe.touch && (strobe.fill || validQ[touchIdx]);

  for (genvar k = 0; k < NUM_FRAMES; k++) begin : g_frame
    logic [WEIGHT_W-1:0] kindWt;
    always_comb begin
      case (kindQ[k])
        KIND_RO:    kindWt = wtReadOnly;
        KIND_OWNED: kindWt = wtOwned;
        default:    kindWt = wtWritable;
      endcase
      score[k] = SCORE_W'(kindWt) + SCORE_W'(wtAge) * SCORE_W'(ageQ[k]);
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        validQ[k] <= 1'b0;
        kindQ[k]  <= KIND_RO;
        ageQ[k]   <= '0;
      end else if (touchOk) begin
        if (touchIdx == IDX_W'(k)) begin
          ageQ[k] <= '0;
          if (strobe.fill) begin
            validQ[k] <= 1'b1;
            kindQ[k]  <= pageKind_e'(fillKind);
          end
        end else if (validQ[k] && ageQ[k] != AGE_MAX) begin
          ageQ[k] <= ageQ[k] + 1'b1;
        end
      end
    end

    AST_AGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ageQ[k] != '0) |-> (ageQ[k] == $past(ageQ[k]) || ageQ[k] == $past(ageQ[k]) + 1'b1));  // R6
  end

  logic [IDX_W-1:0]  invIdx, bestIdx, selIdx;
  logic              anyInvalid;
  logic [SCORE_W-1:0] bestScore;
  logic [NODE_W-1:0] freeNode;
  logic              selXfer;

  always_comb begin
    anyInvalid = 1'b0;
    invIdx     = '0;
    for (int k = NUM_FRAMES - 1; k >= 0; k--) begin
      if (!validQ[k]) begin
        anyInvalid = 1'b1;
        invIdx     = IDX_W'(k);
      end
    end
    bestIdx   = '0;
    bestScore = score[0];
    for (int k = 1; k < NUM_FRAMES; k++) begin
      if (score[k] > bestScore) begin
        bestScore = score[k];
        bestIdx   = IDX_W'(k);
      end
    end
    selIdx  = anyInvalid ? invIdx : bestIdx;
    selXfer = !anyInvalid && (kindQ[selIdx] != KIND_RO);
    freeNode = '0;
    for (int n = NODE_CNT - 1; n >= 0; n--) begin
      if (freeNodeMask[n]) freeNode = NODE_W'(n);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      respIdx   <= '0;
      respXfer  <= 1'b0;
      respNode  <= '0;
      respStall <= 1'b0;
    end else if (strobe.capture) begin
      respIdx   <= selIdx;
      respXfer  <= selXfer;
      respNode  <= freeNode;
      respStall <= selXfer && (freeNodeMask == '0);
    end
  end

  AST_EMPTY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    anyInvalid |-> !validQ[selIdx]);  // R3
  for (genvar k = 0; k < NUM_FRAMES; k++) begin : g_chk
    AST_BEST_SCORE: assert property (@(posedge clk) disable iff (!rst_n)
      !anyInvalid |-> score[k] <= score[selIdx]);  // R4
    AST_TIE_LOW_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
      (!anyInvalid && score[k] == score[selIdx]) |-> (IDX_W'(k) >= selIdx));  // R5
  end
  AST_STALL_ONLY_SHIP: assert property (@(posedge clk) disable iff (!rst_n)
    respStall |-> respXfer);  // R9

endmodule

// File: rtl/victim_sel.sv
module victim_sel
  import victim_sel_pkg::*;
#(
  parameter int NUM_FRAMES = 8,
  parameter int AGE_W      = 4,
  parameter int WEIGHT_W   = 8,
  parameter int NODE_CNT   = 4,
  localparam int IDX_W     = $clog2(NUM_FRAMES),
  localparam int NODE_W    = (NODE_CNT > 1) ? $clog2(NODE_CNT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fillValid,
  input  logic [IDX_W-1:0]    fillIdx,
  input  logic [1:0]          fillKind,
  input  logic                accValid,
  input  logic [IDX_W-1:0]    accIdx,
  input  logic [WEIGHT_W-1:0] wtReadOnly,
  input  logic [WEIGHT_W-1:0] wtOwned,
  input  logic [WEIGHT_W-1:0] wtWritable,
  input  logic [WEIGHT_W-1:0] wtAge,
  input  logic [NODE_CNT-1:0] freeNodeMask,
  input  logic                reqValid,
  output logic                respValid,
  output logic [IDX_W-1:0]    respIdx,
  output logic                respXfer,
  output logic [NODE_W-1:0]   respNode,
  output logic                respStall
);

  ctrlStrobe_t      strobe;
  logic [IDX_W-1:0] touchIdx;

  victim_sel_ctrl #(.IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .fillValid(fillValid), .fillIdx(fillIdx),
    .accValid(accValid), .accIdx(accIdx),
    .reqValid(reqValid),
    .strobe(strobe), .touchIdx(touchIdx), .respValid(respValid)
  );

  victim_sel_dp #(
    .NUM_FRAMES(NUM_FRAMES), .AGE_W(AGE_W),
    .WEIGHT_W(WEIGHT_W), .NODE_CNT(NODE_CNT)
  ) dp_i (
    .clk(clk), .rst_n(rst_n),
    .strobe(strobe), .touchIdx(touchIdx), .fillKind(fillKind),
    .wtReadOnly(wtReadOnly), .wtOwned(wtOwned),
    .wtWritable(wtWritable), .wtAge(wtAge),
    .freeNodeMask(freeNodeMask),
    .respIdx(respIdx), .respXfer(respXfer),
    .respNode(respNode), .respStall(respStall)
  );

endmodule

// File: tb/victim_sel_tb_top.sv
module victim_sel_tb_top;

  localparam int OP_FILL = 0, OP_ACC = 1, OP_REQ = 2;

  typedef struct packed {
    logic [1:0] op;
    logic [2:0] idx;
    logic [1:0] kind;
    logic [3:0] mask;
    logic [2:0] eIdx;
    logic       eXfer;
    logic [1:0] eNode;
    logic       eStall;
  } vec_t;

  // weights for this table: read-only 40, owned 10, writable 0, age x3
  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{2'd2, 3'd0, 2'd0, 4'b0000, 3'd0, 1'b0, 2'd0, 1'b0},  // R1 R3 empty table
    '{2'd0, 3'd0, 2'd0, 4'b0000, 3'd0, 1'b0, 2'd0, 1'b0},
    '{2'd0, 3'd1, 2'd1, 4'b0000, 3'd0, 1'b0, 2'd0, 1'b0},
    '{2'd2, 3'd0, 2'd0, 4'b0000, 3'd2, 1'b0, 2'd0, 1'b0},  // R3 lowest empty
    '{2'd0, 3'd2, 2'd2, 4'b0000, 3'd0, 1'b0, 2'd0, 1'b0},
    '{2'd0, 3'd3, 2'd0, 4'b0000, 3'd0, 1'b0, 2'd0, 1'b0},
    '{2'd0, 3'd4, 2'd1, 4'b0000, 3'd0, 1'b0, 2'd0, 1'b0},
    '{2'd0, 3'd5, 2'd2, 4'b0000, 3'd0, 1'b0, 2'd0, 1'b0},
    '{2'd0, 3'd6, 2'd0, 4'b0000, 3'd0, 1'b0, 2'd0, 1'b0},
    '{2'd0, 3'd7, 2'd1, 4'b0000, 3'd0, 1'b0, 2'd0, 1'b0},
    '{2'd2, 3'd0, 2'd0, 4'b0100, 3'd0, 1'b0, 2'd2, 1'b0},  // R4 R7 frame0 scores 61
    '{2'd1, 3'd0, 2'd0, 4'b0000, 3'd0, 1'b0, 2'd0, 1'b0},
    '{2'd2, 3'd0, 2'd0, 4'b0000, 3'd3, 1'b0, 2'd0, 1'b0},  // R6 frame3 scores 55
    '{2'd1, 3'd3, 2'd0, 4'b0000, 3'd0, 1'b0, 2'd0, 1'b0},
    '{2'd2, 3'd0, 2'd0, 4'b0011, 3'd6, 1'b0, 2'd0, 1'b0},  // R4 frame6 scores 49
    '{2'd1, 3'd6, 2'd0, 4'b0000, 3'd0, 1'b0, 2'd0, 1'b0},
    '{2'd2, 3'd0, 2'd0, 4'b0000, 3'd0, 1'b0, 2'd0, 1'b0},  // R4 frame0 scores 46
    '{2'd1, 3'd0, 2'd0, 4'b0000, 3'd0, 1'b0, 2'd0, 1'b0},
    '{2'd2, 3'd0, 2'd0, 4'b0000, 3'd3, 1'b0, 2'd0, 1'b0}   // R4 frame3 scores 46
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic fillValid = 0, accValid = 0, reqValid = 0;
  logic [2:0] fillIdx = 0, accIdx = 0;
  logic [1:0] fillKind = 0;
  logic [7:0] wtReadOnly = 0, wtOwned = 0, wtWritable = 0, wtAge = 0;
  logic [3:0] freeNodeMask = 0;
  logic respValid, respXfer, respStall;
  logic [2:0] respIdx;
  logic [1:0] respNode;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  victim_sel dut_i (
    .clk(clk), .rst_n(rst_n),
    .fillValid(fillValid), .fillIdx(fillIdx), .fillKind(fillKind),
    .accValid(accValid), .accIdx(accIdx),
    .wtReadOnly(wtReadOnly), .wtOwned(wtOwned), .wtWritable(wtWritable), .wtAge(wtAge),
    .freeNodeMask(freeNodeMask), .reqValid(reqValid),
    .respValid(respValid), .respIdx(respIdx), .respXfer(respXfer),
    .respNode(respNode), .respStall(respStall)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doOp(input int op, input int idx, input int kind, input logic [3:0] mask);
    @(negedge clk);
    fillValid = (op == OP_FILL); accValid = (op == OP_ACC); reqValid = (op == OP_REQ);
    fillIdx = 3'(idx); accIdx = 3'(idx); fillKind = 2'(kind); freeNodeMask = mask;
    @(negedge clk);
    fillValid = 0; accValid = 0; reqValid = 0;
  endtask

  task automatic expectResp(input string req, input int eIdx, input int eXfer,
                            input int eNode, input int eStall);
    check("R2", "respValid", int'(respValid), 1);
    check(req, "respIdx", int'(respIdx), eIdx);
    check(req, "respXfer", int'(respXfer), eXfer);
    check(req, "respNode", int'(respNode), eNode);
    check(req, "respStall", int'(respStall), eStall);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "respValid after reset", int'(respValid), 0);
    rst_n = 1'b1;
    wtReadOnly = 8'd40; wtOwned = 8'd10; wtWritable = 8'd0; wtAge = 8'd3;
    for (int v = 0; v < NV; v++) begin
      doOp(int'(VECS[v].op), int'(VECS[v].idx), int'(VECS[v].kind), VECS[v].mask);
      if (VECS[v].op == 2'(OP_REQ))
        expectResp("R4", int'(VECS[v].eIdx), int'(VECS[v].eXfer),
                   int'(VECS[v].eNode), int'(VECS[v].eStall));
      else
        check("R2", "respValid idle", int'(respValid), 0);
    end
    // ages now 0,10,9,2,7,6,1,4; kinds RO,OWN,WR,RO,OWN,WR,RO,OWN
    wtReadOnly = 0; wtOwned = 0; wtWritable = 0; wtAge = 1;
    doOp(OP_REQ, 0, 0, 4'b1000);
    expectResp("R8", 1, 1, 3, 0);        // R8 owned victim ships, R9 node 3
    doOp(OP_REQ, 0, 0, 4'b0000);
    expectResp("R9", 1, 1, 0, 1);        // R9 stall with no free node
    wtAge = 0;
    doOp(OP_REQ, 0, 0, 4'b0001);
    expectResp("R5", 0, 0, 0, 0);        // R5 all scores equal
    wtWritable = 1; wtAge = 1;
    for (int i = 0; i < 20; i++) doOp(OP_ACC, 0, 0, 4'b0000);
    doOp(OP_REQ, 0, 0, 4'b0110);
    expectResp("R6", 2, 1, 1, 0);        // R6 saturated ages, writable wins
    doOp(OP_ACC, 0, 0, 4'b0000);
    check("R2", "respValid single cycle", int'(respValid), 0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R1", "respValid after second reset", int'(respValid), 0);
    doOp(OP_REQ, 0, 0, 4'b0001);
    expectResp("R1", 0, 0, 0, 0);        // R1 table emptied by reset
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule